// File: doc/BRIEF.md
# Arbitrated Host Write Port for a Shared RAM and Register File

This block accepts single-word writes from an asynchronous host processor and commits them into a shared word RAM or a small register file. The RAM is also owned by an internal protocol engine, represented here only by a request input and a grant output. The host starts an access by pulling its select and strobe lines low. The port synchronizes that request, arbitrates it against the engine, and answers with two active-low handshake outputs. A transfer-enable line marks the host's ownership of the storage. A ready line tells the host the word has been stored.

The control lines (storage target and direction) stay transparent until the first falling clock edge after transfer-enable drops, and are held from then on. Address and data stay transparent until the capture rising edge. The write takes place at that capture edge. A request first seen in the half-cycle just before its sampling edge is treated as marginal, and one extra clock comes before the capture edge. A host request that keeps losing to the engine wins after a parameterized number of lost edges. This puts a hard bound on how long the start of a host cycle can be deferred. The engine reads the stored words through combinational ports.

Top module: `host_wr_port`

## Requirements
- R1: With eng_req low, ioen_n goes low at the third rising edge after sel_n and stb_n are both driven low. The request passes through a two-flop synchronizer and is then acted on at the next edge.
- R2: If eng_req is high at an edge where the port is idle, no host cycle starts and eng_gnt is high from that edge on. eng_gnt is never high while ioen_n is low. An engine request raised during a host cycle is granted at the first edge after ioen_n has returned high.
- R3: After the synchronized host request has lost DEFER_MAX edges in a row to the engine, the host cycle starts at the next edge whatever eng_req is.
- R4: ready_n falls at the third rising edge after the edge that drove ioen_n low. It falls at the fourth edge when the request first became visible after the falling edge that precedes its first sampling rising edge. ready_n is only low while ioen_n is low.
- R5: host_mem and host_dir are taken live until the first falling clock edge after ioen_n goes low. Changes after that edge have no effect on the cycle.
- R6: host_addr and host_wdata are taken at the capture edge. This is the first rising edge after ioen_n goes low, or the second one for a marginal request. Changes before that edge are used and changes after it are ignored.
- R7: host_mem = 1 writes the RAM word at host_addr[11:0]. host_mem = 0 writes register host_addr[4:0]. The upper address bits are ignored.
- R8: With host_wpol = 1 the cycle writes when host_dir = 0. With host_wpol = 0 it writes when host_dir = 1.
- R9: Once ioen_n is low, raising sel_n does not abort the cycle. After the host raises stb_n, ioen_n and ready_n both return high at the third rising edge.
- R10: A cycle whose direction is not a write completes the same handshake and leaves the RAM and the register file unchanged.
- R11: While reset is high, ioen_n and ready_n are high and eng_gnt is low, and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Host select, active low, asynchronous |
| host_stb_n | input | 1 | Host strobe, active low, asynchronous |
| host_mem | input | 1 | Target: 1 RAM, 0 register file |
| host_dir | input | 1 | Direction line, sense set by host_wpol |
| host_wpol | input | 1 | Direction polarity: 1 means low is write, 0 means high is write |
| host_addr | input | 16 | Host word address |
| host_wdata | input | 16 | Host write data |
| ioen_n | output | 1 | Transfer enable to host, active low |
| ready_n | output | 1 | Write complete to host, active low |
| eng_req | input | 1 | Protocol engine storage request |
| eng_gnt | output | 1 | Storage granted to engine |
| eng_ram_addr | input | RAM_AW | Engine RAM read address |
| eng_ram_data | output | 16 | Engine RAM read data |
| eng_reg_addr | input | REG_AW | Engine register read index |
| eng_reg_data | output | 16 | Engine register read data |

## Verification
The bench builds the port with the default 12-bit RAM index and 5-bit register index, so the address aliasing of R7 is checked on the real storage sizes. It lowers DEFER_MAX to 6. With that value the forced host start after a long engine hold (R3) happens within a few cycles, and it can be told apart from a start that follows the engine dropping its request. Request timing on both sides of the falling edge reaches the one-cycle stretch of R4 and R6.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

    localparam int HWP_ADDR_W = 16;
    localparam int HWP_DATA_W = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LATE,
        PH_ADDR,
        PH_POST,
        PH_ARM,
        PH_DONE
    } hwp_phase_e;

    typedef struct packed {
        logic to_ram;
        logic dir;
    } hwp_ctl_t;

    typedef struct packed {
        logic                  to_ram;
        logic [HWP_ADDR_W-1:0] addr;
        logic [HWP_DATA_W-1:0] data;
    } hwp_wr_t;

    // Direction decode: polarity 1 -> low line writes, polarity 0 -> high line writes
    function automatic logic hwp_is_write(input logic pol, input logic dir);
        return pol ? ~dir : dir;
    endfunction

endpackage

// File: rtl/hwp_sync.sv
module hwp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hwp_negedge_unit.sv
module hwp_negedge_unit
    import hwp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ioen_n,
    input  logic     req_raw,
    input  hwp_ctl_t ctl_live,
    output logic     late_raw,
    output hwp_ctl_t ctl_eff
);
    logic     req_neg;
    logic     held;
    hwp_ctl_t ctl_q;

    // Request seen at the falling edge; a request absent there is marginal
    always_ff @(negedge clk) begin
        if (rst) req_neg <= 1'b0;
        else     req_neg <= req_raw;
    end
    assign late_raw = req_raw & ~req_neg;

    // Control latch: closes at the first falling edge of an enabled cycle
    always_ff @(negedge clk) begin
        if (rst) begin
            held  <= 1'b0;
            ctl_q <= '0;
        end else if (ioen_n) begin
            held  <= 1'b0;
        end else if (!held) begin
            held  <= 1'b1;
            ctl_q <= ctl_live;
        end
    end

    assign ctl_eff = held ? ctl_q : ctl_live;

    assert_ctl_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (held && $past(held)) |-> $stable(ctl_q));

    assert_ctl_closed_R5: assert property (@(posedge clk) disable iff (rst)
        (!ioen_n && $past(!ioen_n)) |-> held);
endmodule

// File: rtl/hwp_seq.sv
module hwp_seq
    import hwp_pkg::*;
#(
    parameter int DEFER_MAX = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    input  logic late_s,
    input  logic stb_hi_s,
    input  logic eng_req,
    output logic ioen_n,
    output logic ready_n,
    output logic eng_gnt,
    output logic cap_en
);
    localparam int DEF_W = $clog2(DEFER_MAX + 1);

    hwp_phase_e        phase;
    logic [DEF_W-1:0]  defer;
    logic              force_host;
    logic              start;

    assign force_host = (defer >= DEF_W'(DEFER_MAX));
    assign start      = (phase == PH_IDLE) && req_s && (!eng_req || force_host);
    assign cap_en     = (phase == PH_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            ioen_n  <= 1'b1;
            ready_n <= 1'b1;
            eng_gnt <= 1'b0;
            defer   <= '0;
        end else begin
            eng_gnt <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase  <= late_s ? PH_LATE : PH_ADDR;
                        ioen_n <= 1'b0;
                        defer  <= '0;
                    end else begin
                        eng_gnt <= eng_req;
                        if (!req_s)             defer <= '0;
                        else if (!force_host)   defer <= defer + 1'b1;
                    end
                end
                PH_LATE: phase <= PH_ADDR;
                PH_ADDR: phase <= PH_POST;
                PH_POST: phase <= PH_ARM;
                PH_ARM: begin
                    ready_n <= 1'b0;
                    phase   <= PH_DONE;
                end
                PH_DONE: begin
                    if (stb_hi_s) begin
                        ioen_n  <= 1'b1;
                        ready_n <= 1'b1;
                        phase   <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_gnt_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(eng_gnt && !ioen_n));

    assert_defer_bound_R3: assert property (@(posedge clk) disable iff (rst)
        defer <= DEF_W'(DEFER_MAX));

    assert_ready_inside_R4: assert property (@(posedge clk) disable iff (rst)
        !ready_n |-> !ioen_n);

    assert_ready_gap_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ioen_n) |=> ready_n);

    assert_release_pair_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ioen_n) |-> $rose(ready_n));
endmodule

// File: rtl/hwp_store.sv
module hwp_store
    import hwp_pkg::*;
#(
    parameter int RAM_AW = 12,
    parameter int REG_AW = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  hwp_wr_t               cmd,
    input  logic [RAM_AW-1:0]     eng_ram_addr,
    output logic [HWP_DATA_W-1:0] eng_ram_data,
    input  logic [REG_AW-1:0]     eng_reg_addr,
    output logic [HWP_DATA_W-1:0] eng_reg_data
);
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int REG_DEPTH = 1 << REG_AW;

    logic [HWP_DATA_W-1:0] ram  [RAM_DEPTH];
    logic [HWP_DATA_W-1:0] regs [REG_DEPTH];
    logic                  unused_addr_bits;

    assign unused_addr_bits = ^cmd.addr[HWP_ADDR_W-1:RAM_AW];

    always_ff @(posedge clk) begin
        if (we && cmd.to_ram) ram[cmd.addr[RAM_AW-1:0]] <= cmd.data;
    end

    for (genvar i = 0; i < REG_DEPTH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && !cmd.to_ram && (cmd.addr[REG_AW-1:0] == REG_AW'(i)))
                regs[i] <= cmd.data;
        end
    end

    assign eng_ram_data = ram[eng_ram_addr];
    assign eng_reg_data = regs[eng_reg_addr];
endmodule

// File: rtl/host_wr_port.sv
module host_wr_port
    import hwp_pkg::*;
#(
    parameter int RAM_AW      = 12,
    parameter int REG_AW      = 5,
    parameter int DEFER_MAX   = 45,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_sel_n,
    input  logic                  host_stb_n,
    input  logic                  host_mem,
    input  logic                  host_dir,
    input  logic                  host_wpol,
    input  logic [HWP_ADDR_W-1:0] host_addr,
    input  logic [HWP_DATA_W-1:0] host_wdata,
    output logic                  ioen_n,
    output logic                  ready_n,
    input  logic                  eng_req,
    output logic                  eng_gnt,
    input  logic [RAM_AW-1:0]     eng_ram_addr,
    output logic [HWP_DATA_W-1:0] eng_ram_data,
    input  logic [REG_AW-1:0]     eng_reg_addr,
    output logic [HWP_DATA_W-1:0] eng_reg_data
);
    localparam int SYNC_W = 3;

    logic              req_raw;
    logic              late_raw;
    logic [SYNC_W-1:0] sync_d;
    logic [SYNC_W-1:0] sync_q;
    logic              req_s, late_s, stb_hi_s;
    logic              cap_en;
    logic              we;
    hwp_ctl_t          ctl_live, ctl_eff;
    hwp_wr_t           cmd;

    assign req_raw  = ~host_sel_n & ~host_stb_n;
    assign ctl_live = '{to_ram: host_mem, dir: host_dir};

    hwp_negedge_unit u_neg (
        .clk      (clk),
        .rst      (rst),
        .ioen_n   (ioen_n),
        .req_raw  (req_raw),
        .ctl_live (ctl_live),
        .late_raw (late_raw),
        .ctl_eff  (ctl_eff)
    );

    assign sync_d = {late_raw, req_raw, host_stb_n};

    hwp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_d),
        .q   (sync_q)
    );

    assign {late_s, req_s, stb_hi_s} = sync_q;

    hwp_seq #(.DEFER_MAX(DEFER_MAX)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_s    (req_s),
        .late_s   (late_s),
        .stb_hi_s (stb_hi_s),
        .eng_req  (eng_req),
        .ioen_n   (ioen_n),
        .ready_n  (ready_n),
        .eng_gnt  (eng_gnt),
        .cap_en   (cap_en)
    );

    assign cmd = '{to_ram: ctl_eff.to_ram, addr: host_addr, data: host_wdata};
    assign we  = cap_en && hwp_is_write(host_wpol, ctl_eff.dir);

    hwp_store #(.RAM_AW(RAM_AW), .REG_AW(REG_AW)) u_store (
        .clk          (clk),
        .rst          (rst),
        .we           (we),
        .cmd          (cmd),
        .eng_ram_addr (eng_ram_addr),
        .eng_ram_data (eng_ram_data),
        .eng_reg_addr (eng_reg_addr),
        .eng_reg_data (eng_reg_data)
    );

    assert_write_in_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        we |-> !ioen_n);

    assert_no_grant_on_write_R2: assert property (@(posedge clk) disable iff (rst)
        we |-> !eng_gnt);
endmodule

// File: tb/host_wr_port_bench.sv
module host_wr_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEFER      = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel_n = 1'b1, host_stb_n = 1'b1;
    logic        host_mem = 1'b1, host_dir = 1'b0, host_wpol = 1'b1;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic        ioen_n, ready_n, eng_gnt;
    logic        eng_req = 1'b0;
    logic [11:0] eng_ram_addr = '0;
    logic [15:0] eng_ram_data;
    logic [4:0]  eng_reg_addr = '0;
    logic [15:0] eng_reg_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    host_wr_port #(.RAM_AW(12), .REG_AW(5), .DEFER_MAX(DEFER)) u_host_wr_port (
        .clk(clk), .rst(rst),
        .host_sel_n(host_sel_n), .host_stb_n(host_stb_n),
        .host_mem(host_mem), .host_dir(host_dir), .host_wpol(host_wpol),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .ioen_n(ioen_n), .ready_n(ready_n),
        .eng_req(eng_req), .eng_gnt(eng_gnt),
        .eng_ram_addr(eng_ram_addr), .eng_ram_data(eng_ram_data),
        .eng_reg_addr(eng_reg_addr), .eng_reg_data(eng_reg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural handshake model ----------------
    int   m_phase = 0, m_el = 0, m_need = 0, m_defer = 0;
    logic m_q1 = 0, m_q2 = 0, m_l1 = 0, m_l2 = 0, m_s1 = 0, m_s2 = 0, m_neg = 0;
    logic m_ioen = 1, m_rdy = 1, m_gnt = 0, m_req = 0;

    always @(negedge clk) m_neg = rst ? 1'b0 : (!host_sel_n && !host_stb_n);

    always @(posedge clk) begin
        m_req = !host_sel_n && !host_stb_n;
        if (rst) begin
            m_phase = 0; m_defer = 0; m_ioen = 1; m_rdy = 1; m_gnt = 0;
            m_q1 = 0; m_q2 = 0; m_l1 = 0; m_l2 = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_gnt = 0;
            if (m_phase == 0) begin
                if (m_q2 && (!eng_req || m_defer >= DEFER)) begin
                    m_ioen = 0; m_need = m_l2 ? 4 : 3; m_el = 0; m_defer = 0; m_phase = 1;
                end else begin
                    m_gnt = eng_req;
                    m_defer = m_q2 ? m_defer + 1 : 0;
                end
            end else if (m_phase == 1) begin
                m_el++;
                if (m_el == m_need) begin m_rdy = 0; m_phase = 2; end
            end else begin
                if (m_s2) begin m_ioen = 1; m_rdy = 1; m_phase = 0; end
            end
            m_l2 = m_l1; m_l1 = m_req && !m_neg;
            m_q2 = m_q1; m_q1 = m_req;
            m_s2 = m_s1; m_s1 = host_stb_n;
        end
    end

    always @(posedge clk) begin
        #3;
        if (!finished) begin
            check("R1 ioen_n per clock", 32'(ioen_n), 32'(m_ioen));
            check("R4 ready_n per clock", 32'(ready_n), 32'(m_rdy));
            check("R2 eng_gnt per clock", 32'(eng_gnt), 32'(m_gnt));
        end
    end

    // ---------------- host tasks ----------------
    task automatic set_bus(input logic mem, input logic dir, input logic pol,
                           input logic [15:0] a, input logic [15:0] d);
        host_mem = mem; host_dir = dir; host_wpol = pol; host_addr = a; host_wdata = d;
    endtask

    task automatic begin_req(input logic late, output int n);
        if (late) @(negedge clk); else @(posedge clk);
        #1;
        host_sel_n = 0; host_stb_n = 0;
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #3; n++;
            if (!ioen_n) break;
        end
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #3; n++;
            if (!ready_n) break;
        end
    endtask

    task automatic end_cycle(output int n);
        @(posedge clk); #1;
        host_stb_n = 1; host_sel_n = 1;
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #3; n++;
            if (ioen_n) break;
        end
    endtask

    task automatic full_write(input logic late, input int exp_rdy, input string tag);
        int a, b, c;
        begin_req(late, a);
        check({tag, " R1 edges to ioen_n low"}, 32'(a), 32'd3);
        wait_ready(b);
        check({tag, " R4 edges to ready_n low"}, 32'(b), 32'(exp_rdy));
        end_cycle(c);
        check({tag, " R9 edges to release"}, 32'(c), 32'd3);
        check({tag, " R9 ready_n high on release"}, 32'(ready_n), 32'd1);
    endtask

    task automatic rd_ram(input logic [11:0] a, input logic [15:0] exp, input string tag);
        eng_ram_addr = a; #1;
        check(tag, 32'(eng_ram_data), 32'(exp));
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic [15:0] exp, input string tag);
        eng_reg_addr = a; #1;
        check(tag, 32'(eng_reg_data), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n, n2, n3;
        repeat (3) @(posedge clk);
        #3;
        check("R11 reset ioen_n", 32'(ioen_n), 32'd1);
        check("R11 reset ready_n", 32'(ready_n), 32'd1);
        check("R11 reset eng_gnt", 32'(eng_gnt), 32'd0);
        rd_reg(5'd9, 16'h0000, "R11 register reset value");
        @(posedge clk); #1; rst = 0;
        repeat (2) @(posedge clk);

        // R7: RAM write, early request
        set_bus(1, 0, 1, 16'h0123, 16'hBEEF);
        full_write(0, 3, "early");
        rd_ram(12'h123, 16'hBEEF, "R7 RAM word written");

        // R4: marginal request adds one clock
        set_bus(1, 0, 1, 16'h0456, 16'h1111);
        full_write(1, 4, "late");
        rd_ram(12'h456, 16'h1111, "R4 late cycle still writes");

        // R7: upper address bits ignored for RAM and registers
        set_bus(1, 0, 1, 16'hF123, 16'h2222);
        full_write(0, 3, "alias");
        rd_ram(12'h123, 16'h2222, "R7 RAM alias of 0xF123");
        set_bus(0, 0, 1, 16'h0FE7, 16'h3333);
        full_write(0, 3, "reg");
        rd_reg(5'd7, 16'h3333, "R7 register 7 from 0x0FE7");

        // R8: inverted polarity writes on high direction
        set_bus(0, 1, 0, 16'h0003, 16'h4444);
        full_write(0, 3, "pol0");
        rd_reg(5'd3, 16'h4444, "R8 polarity 0 write");

        // R10: read-direction cycles leave storage unchanged
        set_bus(0, 1, 1, 16'h0003, 16'h5555);
        full_write(0, 3, "read1");
        rd_reg(5'd3, 16'h4444, "R10 register untouched by read");
        set_bus(1, 0, 0, 16'h0123, 16'h6666);
        full_write(0, 3, "read0");
        rd_ram(12'h123, 16'h2222, "R10 RAM untouched by read (R8 sense)");

        // R5: control live before the falling edge
        set_bus(0, 0, 1, 16'h0010, 16'h7777);
        begin_req(0, n);
        host_mem = 1;
        wait_ready(n); end_cycle(n);
        rd_ram(12'h010, 16'h7777, "R5 target taken before falling edge");
        rd_reg(5'd16, 16'h0000, "R5 register 16 not written");

        // R5: control held after the falling edge
        set_bus(1, 0, 1, 16'h0020, 16'h8888);
        begin_req(0, n);
        @(negedge clk); #1;
        host_mem = 0; host_dir = 1;
        wait_ready(n); end_cycle(n);
        rd_ram(12'h020, 16'h8888, "R5 late control change ignored");
        rd_reg(5'd0, 16'h0000, "R5 register 0 not written");

        // R6: address/data before capture used, after capture ignored
        set_bus(1, 0, 1, 16'h0032, 16'h1234);
        full_write(0, 3, "pre");
        set_bus(1, 0, 1, 16'h0030, 16'h9999);
        begin_req(0, n);
        host_addr = 16'h0031; host_wdata = 16'hAAAA;
        wait_ready(n);
        host_addr = 16'h0032; host_wdata = 16'hBBBB;
        end_cycle(n);
        rd_ram(12'h031, 16'hAAAA, "R6 pre-capture address used");
        rd_ram(12'h032, 16'h1234, "R6 post-capture change ignored");

        // R6: late capture edge is one clock later
        set_bus(1, 0, 1, 16'h0040, 16'hCCC0);
        begin_req(1, n);
        @(posedge clk); #1;
        host_addr = 16'h0041; host_wdata = 16'hCCCC;
        wait_ready(n); end_cycle(n);
        rd_ram(12'h041, 16'hCCCC, "R6 late capture uses later address");

        // R9: select released early does not abort
        set_bus(0, 0, 1, 16'h0011, 16'hD00D);
        begin_req(0, n);
        host_sel_n = 1;
        wait_ready(n2);
        check("R9 ready after select release", 32'(n2), 32'd3);
        end_cycle(n3);
        rd_reg(5'd17, 16'hD00D, "R9 write completed after select release");

        // R2/R3: engine holds, host forced after DEFER lost edges
        @(posedge clk); #1; eng_req = 1;
        @(posedge clk); #3;
        check("R2 engine granted when idle", 32'(eng_gnt), 32'd1);
        set_bus(1, 0, 1, 16'h0050, 16'h5050);
        begin_req(0, n);
        check("R3 forced start after DEFER lost edges", 32'(n), 32'(3 + DEFER));
        check("R2 grant dropped during host cycle", 32'(eng_gnt), 32'd0);
        wait_ready(n); end_cycle(n);
        check("R2 no grant at release edge", 32'(eng_gnt), 32'd0);
        @(posedge clk); #3;
        check("R2 grant after release", 32'(eng_gnt), 32'd1);
        rd_ram(12'h050, 16'h5050, "R3 forced write stored");
        #1; eng_req = 0;
        repeat (2) @(posedge clk);

        // R2: host waits for engine to drop
        set_bus(1, 0, 1, 16'h0060, 16'h6060);
        @(posedge clk); #1;
        eng_req = 1; host_sel_n = 0; host_stb_n = 0;
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #1; n++;
            if (n == 4) eng_req = 0;
            #2;
            if (!ioen_n) break;
        end
        check("R2 host starts at edge after engine drops", 32'(n), 32'd5);
        wait_ready(n); end_cycle(n);
        rd_ram(12'h060, 16'h6060, "R2 deferred write stored");

        repeat (3) @(posedge clk);
        #4;
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule